// File: doc/BRIEF.md
# Phase Accumulator With Triangle Output

This block is a numerically controlled oscillator for a frequency-scan waveform source. On every enabled clock it adds a tuning word, which a scan sequencer supplies, to a 24-bit phase register. The phase register wraps modulo 2^24, so the output frequency is the clock frequency times the tuning word divided by 2^24. The sequencer can change the tuning word at any time. The phase is never cleared by such a change, so every frequency step is phase-continuous.

The upper ten phase bits leave the block on a lookup port, and an external sine table answers in the same cycle. In sine mode the table answer becomes the 10-bit amplitude code. In triangle mode the table is bypassed. The phase is instead folded into a linear ramp that rises over the first half of each cycle and falls over the second. A square wave is taken as the inverse of the amplitude code's top bit, and its own enable gates it. A clear input (reset or interrupt) parks the output at midscale until the next scan start. A start input sets the phase to zero, so each scan begins from a known phase. A standby input freezes everything in place.

Top module: `nco_tri_gen`

## Requirements
- R1: While `rst_n` is low, and after it rises until a start, `amp_code` is 512, `lut_phase` is 0 and `square_o` is 0.
- R2: A `start_i` pulse, when `standby` and `clear_i` are low, sets the phase to zero and enables accumulation at that clock edge. The amplitude code computed from phase zero appears one clock later (code 0 in triangle mode).
- R3: While accumulation is enabled and no start, clear or standby is present, the phase becomes (phase + `tuning_word`) mod 2^24 at each clock edge, and `lut_phase` always shows phase bits 23:14.
- R4: A change of `tuning_word` never clears or reloads the phase; the next sum uses the phase held at that moment.
- R5: With `wave_sel` = 1 (sine) and accumulation enabled, `amp_code` takes the `lut_data` value present in the previous cycle.
- R6: With `wave_sel` = 0 (triangle), `amp_code` takes, one cycle after the phase, F·2 + F[8], where F = phase[22:14] when phase[23] = 0 and F = 511 − phase[22:14] when phase[23] = 1.
- R7: `square_oe` equals `sq_en`. When `sq_en` = 1, `square_o` is the inverse of `amp_code[9]`; when `sq_en` = 0, `square_o` is 0.
- R8: While `standby` is high, the phase, the run state and `amp_code` hold their values, and `start_i` and `clear_i` have no effect. Accumulation resumes on the first edge with `standby` low.
- R9: `clear_i` (with `standby` low) returns `amp_code` to 512 and the phase to 0 at the next edge and stops accumulation until the next start. It takes priority over a simultaneous `start_i`.
- R10: While accumulation is disabled, `amp_code` stays at 512 whatever `tuning_word`, `wave_sel` or `lut_data` show.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Freeze all state while high |
| clear_i | input | 1 | Reset/interrupt: midscale output, phase zero, stop |
| start_i | input | 1 | Scan start: phase zero, begin accumulating |
| tuning_word | input | 24 | Phase increment per clock |
| wave_sel | input | 1 | 1 = sine via lookup port, 0 = triangle |
| sq_en | input | 1 | Enable for the square output |
| lut_phase | output | 10 | Truncated phase to the external sine table |
| lut_data | input | 10 | Sine table answer for `lut_phase` |
| amp_code | output | 10 | Registered amplitude code (offset binary) |
| square_o | output | 1 | Inverted amplitude MSB, 0 when disabled |
| square_oe | output | 1 | Output enable for the square pin driver |

## Verification
The bench builds the block with its default widths: a 24-bit phase and a 10-bit amplitude. At these widths the lookup port carries the same bits that drive the triangle fold. The bench uses large tuning words, around 2^18 to 2^23. With these, the phase wraps within a few dozen cycles, which brings the fold boundary at phase bit 23 and the modular wrap of the adder within reach many times over. The bench's stand-in sine table is a scrambling of the lookup phase, so any lag or bit slip between `lut_phase` and `amp_code` shows up as a wrong code.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef enum logic {
    WAVE_TRI  = 1'b0,
    WAVE_SINE = 1'b1
  } wave_e;

  // Offset-binary midscale for a code of the given width.
  function automatic int unsigned mid_of(input int unsigned w);
    return 32'd1 << (w - 1);
  endfunction
endpackage

// File: rtl/nco_ctrl.sv
module nco_ctrl (
  input  logic standby,
  input  logic clear_i,
  input  logic start_i,
  input  logic running_q,
  output logic clear_evt,
  output logic start_evt,
  output logic adv_evt,
  output logic live
);
  // Standby gates every event; clear outranks start, start outranks advance.
  assign live      = ~standby;
  assign clear_evt = live & clear_i;
  assign start_evt = live & start_i & ~clear_i;
  assign adv_evt   = live & running_q & ~clear_i & ~start_i;
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int PHASE_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_evt,
  input  logic               start_evt,
  input  logic               adv_evt,
  input  logic [PHASE_W-1:0] tuning_word,
  output logic [PHASE_W-1:0] phase_q,
  output logic               running_q
);
  function automatic logic [PHASE_W-1:0] wrap_add(
    input logic [PHASE_W-1:0] a,
    input logic [PHASE_W-1:0] b
  );
    return a + b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= '0;
      running_q <= 1'b0;
    end else if (clear_evt) begin
      phase_q   <= '0;
      running_q <= 1'b0;
    end else if (start_evt) begin
      phase_q   <= '0;
      running_q <= 1'b1;
    end else if (adv_evt) begin
      phase_q   <= wrap_add(phase_q, tuning_word);
    end
  end
endmodule

// File: rtl/nco_shaper.sv
module nco_shaper
  import nco_pkg::*;
#(
  parameter int PHASE_W = 24,
  parameter int AMP_W   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               live,
  input  logic               clear_evt,
  input  logic               running_q,
  input  logic               wave_sel,
  input  logic               sq_en,
  input  logic [PHASE_W-1:0] phase_q,
  input  logic [AMP_W-1:0]   lut_data,
  output logic [AMP_W-1:0]   amp_code,
  output logic               square_o,
  output logic               square_oe
);
  localparam int FOLD_W = AMP_W - 1;
  localparam logic [AMP_W-1:0] MID = AMP_W'(mid_of(AMP_W));

  // Fold the phase below the MSB about the MSB, then widen by
  // repeating the fold's top bit so the ramp spans the full code range.
  function automatic logic [AMP_W-1:0] tri_shape(input logic [PHASE_W-1:0] p);
    logic [FOLD_W-1:0] f;
    f = p[PHASE_W-2 -: FOLD_W] ^ {FOLD_W{p[PHASE_W-1]}};
    return {f, f[FOLD_W-1]};
  endfunction

  wave_e            mode;
  logic [AMP_W-1:0] shaped;
  logic [AMP_W-1:0] amp_q;

  assign mode = wave_e'(wave_sel);

  always_comb begin
    unique case (mode)
      WAVE_SINE: shaped = lut_data;
      default:   shaped = tri_shape(phase_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      amp_q <= MID;
    else if (live)
      amp_q <= (clear_evt || !running_q) ? MID : shaped;
  end

  assign amp_code  = amp_q;
  assign square_oe = sq_en;
  assign square_o  = sq_en & ~amp_q[AMP_W-1];
endmodule

// File: rtl/nco_tri_gen.sv
module nco_tri_gen #(
  parameter int PHASE_W = 24,
  parameter int AMP_W   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               standby,
  input  logic               clear_i,
  input  logic               start_i,
  input  logic [PHASE_W-1:0] tuning_word,
  input  logic               wave_sel,
  input  logic               sq_en,
  output logic [AMP_W-1:0]   lut_phase,
  input  logic [AMP_W-1:0]   lut_data,
  output logic [AMP_W-1:0]   amp_code,
  output logic               square_o,
  output logic               square_oe
);
  // Internal events, named for the checker.
  logic               clear_evt;
  logic               start_evt;
  logic               adv_evt;
  logic               live;
  logic [PHASE_W-1:0] phase_q;
  logic               running_q;

  nco_ctrl u_ctrl (
    .standby   (standby),
    .clear_i   (clear_i),
    .start_i   (start_i),
    .running_q (running_q),
    .clear_evt (clear_evt),
    .start_evt (start_evt),
    .adv_evt   (adv_evt),
    .live      (live)
  );

  nco_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_evt   (clear_evt),
    .start_evt   (start_evt),
    .adv_evt     (adv_evt),
    .tuning_word (tuning_word),
    .phase_q     (phase_q),
    .running_q   (running_q)
  );

  assign lut_phase = phase_q[PHASE_W-1 -: AMP_W];

  nco_shaper #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_shape (
    .clk       (clk),
    .rst_n     (rst_n),
    .live      (live),
    .clear_evt (clear_evt),
    .running_q (running_q),
    .wave_sel  (wave_sel),
    .sq_en     (sq_en),
    .phase_q   (phase_q),
    .lut_data  (lut_data),
    .amp_code  (amp_code),
    .square_o  (square_o),
    .square_oe (square_oe)
  );
endmodule

// File: rtl/nco_tri_gen_chk.sv
module nco_tri_gen_chk #(
  parameter int PHASE_W = 24,
  parameter int AMP_W   = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               standby,
  input logic               sq_en,
  input logic [PHASE_W-1:0] tuning_word,
  input logic [PHASE_W-1:0] phase_q,
  input logic               running_q,
  input logic               clear_evt,
  input logic               start_evt,
  input logic               adv_evt,
  input logic [AMP_W-1:0]   amp_code,
  input logic               square_o,
  input logic               square_oe
);
  localparam logic [AMP_W-1:0] MID = AMP_W'(nco_pkg::mid_of(AMP_W));

  // R3 R4
  accum_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> phase_q == $past(phase_q) + $past(tuning_word));

  // R2
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (phase_q == '0) && running_q);

  // R9
  clear_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> (amp_code == MID) && !running_q && (phase_q == '0));

  // R8
  standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> $stable(phase_q) && $stable(amp_code) && $stable(running_q));

  // R10
  idle_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_q && !standby) |=> amp_code == MID);

  // R7
  square_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sq_en |-> !square_o && !square_oe);

  // R7
  square_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    square_oe |-> square_o != amp_code[AMP_W-1]);
endmodule

bind nco_tri_gen nco_tri_gen_chk #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .standby     (standby),
  .sq_en       (sq_en),
  .tuning_word (tuning_word),
  .phase_q     (phase_q),
  .running_q   (running_q),
  .clear_evt   (clear_evt),
  .start_evt   (start_evt),
  .adv_evt     (adv_evt),
  .amp_code    (amp_code),
  .square_o    (square_o),
  .square_oe   (square_oe)
);

// File: tb/nco_tri_gen_test.sv
module nco_tri_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 24;
  localparam int AW = 10;
  localparam int MIDV = 512;
  localparam int WATCHDOG_CYC = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          standby = 1'b0;
  logic          clear_i = 1'b0;
  logic          start_i = 1'b0;
  logic [PW-1:0] tuning_word = '0;
  logic          wave_sel = 1'b0;
  logic          sq_en = 1'b0;
  logic [AW-1:0] lut_phase;
  logic [AW-1:0] lut_data;
  logic [AW-1:0] amp_code;
  logic          square_o;
  logic          square_oe;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // Bench model state
  logic [PW-1:0] m_ph = '0;
  bit            m_run = 0;
  int            m_amp = MIDV;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Stand-in sine table: a fixed scramble of the lookup phase.
  function automatic logic [AW-1:0] table_of(input logic [AW-1:0] a);
    return {a[3:0], a[9:4]} ^ 10'h2A5;
  endfunction
  assign lut_data = table_of(lut_phase);

  function automatic int tri_ref(input logic [PW-1:0] p);
    int top9;
    int f;
    top9 = int'(p[22:14]);
    f = p[23] ? (511 - top9) : top9;
    return f * 2 + f / 256;
  endfunction

  nco_tri_gen uut (
    .clk(clk), .rst_n(rst_n), .standby(standby), .clear_i(clear_i),
    .start_i(start_i), .tuning_word(tuning_word), .wave_sel(wave_sel),
    .sq_en(sq_en), .lut_phase(lut_phase), .lut_data(lut_data),
    .amp_code(amp_code), .square_o(square_o), .square_oe(square_oe)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int sq_exp;
    sq_exp = sq_en ? ((m_amp >= MIDV) ? 0 : 1) : 0;
    check(tag, int'(amp_code), m_amp, "amp_code");
    check(tag, int'(lut_phase), int'(m_ph[23:14]), "lut_phase");
    check(tag, int'(square_o), sq_exp, "square_o");
    check(tag, int'(square_oe), int'(sq_en), "square_oe");
  endtask

  // One clock: model the edge with the inputs held since the last negedge,
  // then compare at the following negedge.
  task automatic tick(input string tag);
    @(posedge clk);
    if (!standby) begin
      if (clear_i) begin
        m_amp = MIDV; m_ph = '0; m_run = 0;
      end else begin
        if (!m_run) m_amp = MIDV;
        else if (wave_sel) m_amp = int'(table_of(m_ph[23:14]));
        else m_amp = tri_ref(m_ph);
        if (start_i) begin
          m_ph = '0; m_run = 1;
        end else if (m_run) begin
          m_ph = m_ph + tuning_word;
        end
      end
    end
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic pulse_start(input string tag);
    start_i = 1'b1; tick(tag); start_i = 1'b0;
  endtask

  initial begin
    int unsigned seed;
    logic [PW-1:0] ph_before;
    seed = 32'd1234;
    void'($urandom(seed));

    // R1: reset state
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    sq_en = 1'b1;
    run(3, "R1");

    // R10: idle with a live tuning word and both modes
    tuning_word = 24'h3A_0001;
    run(5, "R10");
    wave_sel = 1'b1;
    run(5, "R10");
    wave_sel = 1'b0;

    // R2: start in triangle mode; first code after start is 0
    tuning_word = 24'h04_0000;
    pulse_start("R2");
    tick("R2");
    check("R2", int'(amp_code), 0, "first triangle code");

    // R6 R3: full triangle cycles, fold across phase bit 23
    run(140, "R6");

    // R4: change tuning word mid-run, phase carries on
    ph_before = m_ph;
    tuning_word = 24'h01_2345;
    tick("R4");
    check("R4", int'(lut_phase), int'(ph_before[23:14] + 0) == 0 ? 0 : int'(m_ph[23:14]), "continued phase");
    run(60, "R4");

    // R5: sine mode through the lookup port
    wave_sel = 1'b1;
    tuning_word = 24'h09_8765;
    run(80, "R5");

    // R7: square enable off and on
    sq_en = 1'b0;
    run(20, "R7");
    sq_en = 1'b1;
    wave_sel = 1'b0;
    run(20, "R7");

    // R8: standby freezes and masks start and clear
    standby = 1'b1;
    run(3, "R8");
    start_i = 1'b1; tick("R8"); start_i = 1'b0;
    clear_i = 1'b1; tick("R8"); clear_i = 1'b0;
    tuning_word = 24'h7F_FFFF;
    run(3, "R8");
    standby = 1'b0;
    run(10, "R8");

    // R9: clear returns to midscale; clear beats start
    clear_i = 1'b1; tick("R9"); clear_i = 1'b0;
    check("R9", int'(amp_code), MIDV, "midscale after clear");
    run(5, "R9");
    pulse_start("R9");
    run(10, "R9");
    clear_i = 1'b1; start_i = 1'b1; tick("R9");
    clear_i = 1'b0; start_i = 1'b0;
    run(6, "R9");

    // R3: constrained random mix of all inputs
    pulse_start("R3");
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = $urandom % 100;
      if (r < 5) tuning_word = PW'($urandom);
      standby = (($urandom % 100) < 6);
      start_i = (($urandom % 100) < 2);
      clear_i = (($urandom % 100) < 1);
      if (($urandom % 100) < 3) wave_sel = ~wave_sel;
      if (($urandom % 100) < 3) sq_en = ~sq_en;
      tick("R3");
    end
    standby = 1'b0; start_i = 1'b0; clear_i = 1'b0;
    run(4, "R3");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule